// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a two-wire synchronous configuration port that feeds a bank of radio control registers. A host raises a select line, then toggles a serial clock while moving bits over one shared data line. The port samples the serial clock and the incoming data into the system clock domain through two-flop synchronisers. It finds serial-clock rising edges there, counts bits and assembles bytes.

The first byte after select rises is a command. Bit 7 set means read and bit 7 clear means write. Bits 3..0 hold the starting register address, and bits 6..4 are ignored. On a write, every later group of eight bits is committed to the addressed register, and the address then steps by one, wrapping from 15 to 0. On a read, the port takes the data line after the command byte. It puts the next bit out at each serial-clock rising edge, MSB first, so the host samples on the falling edge, and the address steps after every eight bits.

The control sequence has four named states. IDLE waits for select. CMD collects the command byte. WDATA collects and commits write bytes. RDATA shifts out register contents. The transitions are as follows:
- IDLE goes to CMD when select is high.
- CMD goes to WDATA or RDATA when the eighth command bit arrives, following bit 7 of the command.
- Any state other than IDLE returns to IDLE as soon as select is low.

Top module: `cfgp_port`

## Requirements
- R1: After reset all 16 eight-bit registers read zero and the data-line enable output is low.
- R2: While select is low, serial-clock and data activity changes no register and leaves the data-line enable low.
- R3: A command byte with bit 7 clear selects a write to the register addressed by its bits 3..0. Data bits are captured MSB first, one per serial-clock rising edge.
- R4: Each completed group of eight data bits is committed to the current register, and the address then increments, wrapping from 15 to 0.
- R5: A command byte with bit 7 set selects a read. At each following serial-clock rising edge the port drives the next bit of the addressed register, MSB first, and holds it until the next rising edge.
- R6: During a read the address increments after every eight bits, so consecutive bytes come from consecutive registers, wrapping from 15 to 0.
- R7: Dropping select discards any partial byte, leaves the registers unchanged, and lowers the data-line enable within one system clock.
- R8: The data-line enable is high only in the read data phase. It stays low during the command byte and during writes.
- R9: After select is dropped, the next transaction starts with a fresh bit count and a new command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Port select from the host, active high |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| sdat_i | input | 1 | Data line as seen at the pad input |
| sdat_o | output | 1 | Data value driven during a read |
| sdat_oe_o | output | 1 | Pad output enable for the data line |
| regs_o | output | 128 | Register bank contents, register n in bits 8n+7..8n |

## Verification
The assertions assume three things about the host. Select changes only while the serial clock is low. Each serial-clock level lasts several system clocks, so every rising edge is seen exactly once after synchronisation. Write data is stable around each rising edge. The stimulus keeps to these rules: every bit holds the serial clock low for eight system clocks and high for six, data changes only in the low phase, and select moves with margin on both sides of a transaction. Transaction type, start address and length are drawn at random, and directed cases cover address wrap, aborted bytes and activity while unselected.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } cfgp_state_e;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[gi] <= 1'b0;
                    stab_q[gi] <= 1'b0;
                end else begin
                    meta_q[gi] <= async_i[gi];
                    stab_q[gi] <= meta_q[gi];
                end
            end
        end
    endgenerate

    assign sync_o = stab_q;
endmodule

// File: rtl/cfgp_edge.sv
module cfgp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic [NREG*DW-1:0] regs_o
);
    logic [DW-1:0] regs_q [NREG];

    genvar gr;
    generate
        for (gr = 0; gr < NREG; gr++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              regs_q[gr] <= '0;
                else if (we_i && (addr_i == AW'(gr)))    regs_q[gr] <= wdata_i;
            end
            assign regs_o[gr*DW +: DW] = regs_q[gr];
        end
    endgenerate

    assign rdata_o = regs_q[addr_i];

    assert_commit_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (regs_o[$past(addr_i)*DW +: DW] == $past(wdata_i)));
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port #(
    parameter int NREG = 16,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               sclk_i,
    input  logic               sdat_i,
    output logic               sdat_o,
    output logic               sdat_oe_o,
    output logic [NREG*DW-1:0] regs_o
);
    import cfgp_pkg::*;

    localparam int AW = $clog2(NREG);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    cfgp_state_e state_q, state_d;

    logic [1:0]    sync_in, sync_out;
    logic          sclk_s, din_s, sclk_rise;
    logic [CW-1:0] bitcnt_q, bit_idx;
    logic [DW-1:0] shreg_q, asm_byte, rd_byte;
    logic [AW-1:0] addr_q;
    logic          byte_done, wr_en;
    logic          sdo_q, oe_q;

    assign sync_in = {sdat_i, sclk_i};

    cfgp_sync #(.WIDTH(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_in),
        .sync_o  (sync_out)
    );

    assign sclk_s = sync_out[0];
    assign din_s  = sync_out[1];

    cfgp_edge edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sclk_s),
        .rise_o  (sclk_rise)
    );

    assign asm_byte  = {shreg_q[DW-2:0], din_s};
    assign byte_done = sclk_rise && (bitcnt_q == LAST_BIT);
    assign bit_idx   = LAST_BIT - bitcnt_q;
    assign wr_en     = sel_i && (state_q == ST_WDATA) && byte_done;

    cfgp_regbank #(.NREG(NREG), .DW(DW)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .addr_i  (addr_q),
        .wdata_i (asm_byte),
        .rdata_o (rd_byte),
        .regs_o  (regs_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel_i) state_d = ST_CMD;
            ST_CMD: begin
                if (!sel_i)         state_d = ST_IDLE;
                else if (byte_done) state_d = asm_byte[DW-1] ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: if (!sel_i) state_d = ST_IDLE;
            ST_RDATA: if (!sel_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // bit counter, shifter, address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            addr_q   <= '0;
        end else if (!sel_i || state_q == ST_IDLE) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
        end else if (sclk_rise) begin
            bitcnt_q <= (bitcnt_q == LAST_BIT) ? '0 : bitcnt_q + 1'b1;
            shreg_q  <= asm_byte;
            if (byte_done) begin
                unique case (state_q)
                    ST_CMD:   addr_q <= asm_byte[AW-1:0];
                    ST_WDATA: addr_q <= addr_q + 1'b1;
                    ST_RDATA: addr_q <= addr_q + 1'b1;
                    default:  addr_q <= addr_q;
                endcase
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= (state_d == ST_RDATA);
            if (sel_i && state_q == ST_RDATA && sclk_rise)
                sdo_q <= rd_byte[bit_idx];
        end
    end

    assign sdat_o    = sdo_q;
    assign sdat_oe_o = oe_q;

    assert_release_on_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !sdat_oe_o);

    assert_no_write_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> $stable(regs_o));

    assert_dout_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(sdat_o));

    assert_oe_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sdat_oe_o |-> (state_q == ST_RDATA));

    assert_no_commit_in_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD) |=> $stable(regs_o));
endmodule

// File: tb/cfgp_port_tb_top.sv
module cfgp_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;
    localparam int DW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_i = 1'b0, sclk_i = 1'b0, sdat_i = 1'b0;
    logic sdat_o, sdat_oe_o;
    logic [NREG*DW-1:0] regs_o;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];

    cfgp_port #(.NREG(NREG), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sclk_i(sclk_i),
        .sdat_i(sdat_i), .sdat_o(sdat_o), .sdat_oe_o(sdat_oe_o), .regs_o(regs_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] cmd_byte(input bit rd, input int addr);
        return {rd, 3'b000, 4'(addr)};
    endfunction

    task automatic check_bank(input string req);
        for (int r = 0; r < NREG; r++)
            check(regs_o[r*8 +: 8] == model[r], req, regs_o[r*8 +: 8], model[r]);
    endtask

    task automatic shift_bit(input logic b, input bit chk_oe_low, output logic rb);
        sdat_i = b;
        tick(4);
        sclk_i = 1'b1;
        tick(6);
        rb = sdat_o;
        if (chk_oe_low) check(sdat_oe_o == 1'b0, "R8 oe low in write", sdat_oe_o, 0);
        sclk_i = 1'b0;
        tick(4);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit chk_oe_low);
        logic rb;
        for (int i = 7; i >= 0; i--) shift_bit(v[i], chk_oe_low, rb);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic rb;
        for (int i = 7; i >= 0; i--) begin
            shift_bit(1'b0, 1'b0, rb);
            check(sdat_oe_o == 1'b1, "R5 oe high in read", sdat_oe_o, 1);
            v[i] = rb;
        end
    endtask

    task automatic begin_txn();
        sel_i = 1'b1;
        tick(4);
    endtask

    task automatic end_txn();
        tick(4);
        sel_i = 1'b0;
        tick(4);
    endtask

    task automatic write_txn(input int addr, input int n, input logic [7:0] d [4]);
        begin_txn();
        send_byte(cmd_byte(1'b0, addr), 1'b0);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], 1'b1);
            model[(addr + k) % NREG] = d[k];
        end
        end_txn();
    endtask

    task automatic read_txn(input int addr, input int n);
        logic [7:0] got;
        begin_txn();
        send_byte(cmd_byte(1'b1, addr), 1'b0);
        for (int k = 0; k < n; k++) begin
            recv_byte(got);
            check(got == model[(addr + k) % NREG], "R6 read byte", got, model[(addr + k) % NREG]);
        end
        end_txn();
        check(sdat_oe_o == 1'b0, "R7 release after read", sdat_oe_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [4];
        logic rb;
        void'($urandom(32'h5eed_c0de));
        for (int r = 0; r < NREG; r++) model[r] = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(3);

        // R1 reset state
        check_bank("R1 reset value");
        check(sdat_oe_o == 1'b0, "R1 oe after reset", sdat_oe_o, 0);

        // R2 activity while unselected
        for (int i = 0; i < 16; i++) shift_bit(1'b1, 1'b0, rb);
        check_bank("R2 unselected");
        check(sdat_oe_o == 1'b0, "R2 oe unselected", sdat_oe_o, 0);

        // R3 single write with distinctive pattern, MSB first
        d[0] = 8'h96; d[1] = 8'h00; d[2] = 8'h00; d[3] = 8'h00;
        write_txn(5, 1, d);
        check(regs_o[5*8 +: 8] == 8'h96, "R3 write capture", regs_o[5*8 +: 8], 8'h96);
        check_bank("R3 bank after write");

        // R4 auto-increment with wrap
        d[0] = 8'hA1; d[1] = 8'h3C; d[2] = 8'h00; d[3] = 8'h00;
        write_txn(15, 2, d);
        check(regs_o[0 +: 8] == 8'h3C, "R4 wrap to 0", regs_o[0 +: 8], 8'h3C);
        check_bank("R4 bank after wrap");

        // R5/R6 read across wrap
        read_txn(15, 3);

        // R7 abort partial write byte
        begin_txn();
        send_byte(cmd_byte(1'b0, 3), 1'b0);
        for (int i = 0; i < 5; i++) shift_bit(1'b1, 1'b1, rb);
        sel_i = 1'b0;
        tick(2);
        check_bank("R7 partial byte discarded");
        check(sdat_oe_o == 1'b0, "R7 oe after abort", sdat_oe_o, 0);
        tick(4);

        // R9 fresh transaction after abort
        d[0] = 8'h5A; d[1] = 8'h00; d[2] = 8'h00; d[3] = 8'h00;
        write_txn(3, 1, d);
        check(regs_o[3*8 +: 8] == 8'h5A, "R9 fresh count", regs_o[3*8 +: 8], 8'h5A);

        // R7 abort during read releases line
        begin_txn();
        send_byte(cmd_byte(1'b1, 3), 1'b0);
        for (int i = 0; i < 3; i++) shift_bit(1'b0, 1'b0, rb);
        sel_i = 1'b0;
        tick(2);
        check(sdat_oe_o == 1'b0, "R7 oe after read abort", sdat_oe_o, 0);
        tick(4);

        // R8 command-only transaction leaves line released
        begin_txn();
        send_byte(cmd_byte(1'b0, 7), 1'b1);
        end_txn();
        check_bank("R8 command only");

        // random mix
        for (int t = 0; t < 40; t++) begin
            int addr, n;
            bit rd;
            addr = int'($urandom_range(0, NREG - 1));
            n    = int'($urandom_range(1, 4));
            rd   = 1'($urandom_range(0, 1));
            if (rd) begin
                read_txn(addr, n);
            end else begin
                for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
                write_txn(addr, n, d);
                check_bank("R4 random write");
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule